// File: doc/BRIEF.md
# Sleep Signal Minimum-Width Stretcher

This block drives two active-low sleep-control outputs: one gates an auxiliary supply well and the other gates the suspend supply well. When a sleep request rises, its output asserts at the next clock edge. The output then stays asserted until the request has been withdrawn and a minimum time has passed, counted in ticks of a 1 ms timebase. This gives the external supplies time to discharge fully and power-cycle.

Each output has its own 2-bit width code, and the two codes map to different durations. The codes sit in a small configuration store. Only the real-time-clock-well reset clears that store, and a lock input freezes it. A disable-after-power-up input, combined with a wake-context input, suppresses stretching when the system resumes from the cold-off or deep-sleep state. Each output also has a status flag that is high while the stretch alone is holding that output asserted.

Top module: `sleep_stretcher`

## Requirements
- R1: While `rst` is high, both sleep outputs are high (deasserted) and both status flags are low. A `rst` pulse in the middle of a stretch releases the output at the next edge.
- R2: `rtc_rst` clears both width codes to 00, so stretching is disabled by default. `rst` leaves the codes unchanged.
- R3: A request that is high at a clock edge while its output is idle drives the output low from that edge. The output stays low for as long as the request stays high.
- R4: Suspend-output durations by width code: 00 gives none, 01 gives 500 ticks, 10 gives 1000 ticks, 11 gives 4000 ticks.
- R5: Auxiliary-output durations by width code: 00 gives none, 01 gives 4000 ticks, 10 gives 98 ticks, 11 gives 2000 ticks.
- R6: The timer starts at zero on the edge where the output asserts and counts one for each edge at which `tick_ms` is high. The output returns high at the first edge where the request is low and the count has reached the duration. With a tick on every cycle and the request held for H cycles, the output is low for max(H, N+1) cycles. With no ticks, a nonzero duration never runs out.
- R7: The width code and the skip decision are captured when the output asserts. A code written during a stretch does not change that stretch; the new code applies from the next assertion.
- R8: While `cfg_lock` is high, writes through `cfg_we` are ignored, and `aux_code` and `sus_code` read back their previous values.
- R9: `wake_ctx` encodes 00 = ordinary, 01 = cold-off exit, 10 = deep-sleep exit, 11 = treated as ordinary. If `cfg_dis_pwrup` is high at assertion and the context is 01 or 10, the auxiliary output gets no stretch.
- R10: If `cfg_dis_pwrup` is high at assertion and the context is 01, the suspend output gets no stretch. With context 10 the suspend output is always stretched. With context 00 or 11, neither output's stretch is skipped.
- R11: A status flag is high exactly while its output is low and its request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output state |
| rtc_rst | input | 1 | Synchronous active-high reset of the width codes |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| req_aux | input | 1 | Auxiliary-well sleep request, active high |
| req_sus | input | 1 | Suspend-well sleep request, active high |
| cfg_we | input | 1 | Width-code write strobe |
| cfg_lock | input | 1 | Blocks width-code writes while high |
| cfg_aux_wdata | input | 2 | Width code written for the auxiliary output |
| cfg_sus_wdata | input | 2 | Width code written for the suspend output |
| cfg_dis_pwrup | input | 1 | Skips stretching on power-up exits |
| wake_ctx | input | 2 | Exit context (see R9) |
| aux_code | output | 2 | Current auxiliary width code |
| sus_code | output | 2 | Current suspend width code |
| slp_aux_n | output | 1 | Auxiliary-well sleep output, active low |
| slp_sus_n | output | 1 | Suspend-well sleep output, active low |
| aux_stretching | output | 1 | Auxiliary output is held by the stretch alone |
| sus_stretching | output | 1 | Suspend output is held by the stretch alone |

## Verification
A wrong captured duration or a miscounting timer shows up as an output that returns high too early or too late. The deviation becomes visible at the release edge, up to 4001 cycles after assertion, so the bench measures every pulse's exact low length along with the number of cycles its status flag is high. A corrupted width code shows up at once on the code read-back ports. A lost active state shows up on the very next cycle, as an output that rises while its request is still high.

// File: rtl/sleep_stretch_pkg.sv
package sleep_stretch_pkg;

    localparam int CNT_W   = 12;
    localparam int NUM_CH  = 2;

    localparam int SUS_D1  = 500;
    localparam int SUS_D2  = 1000;
    localparam int SUS_D3  = 4000;
    localparam int AUX_D1  = 4000;
    localparam int AUX_D2  = 98;
    localparam int AUX_D3  = 2000;

    typedef enum logic [1:0] {
        CTX_NONE = 2'b00,
        CTX_COLD = 2'b01,
        CTX_DEEP = 2'b10,
        CTX_RSVD = 2'b11
    } wake_ctx_e;

    typedef enum logic {
        CH_AUX = 1'b0,
        CH_SUS = 1'b1
    } chan_e;

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } chan_state_t;

    function automatic logic [CNT_W-1:0] code_ticks(chan_e ch, logic [1:0] code);
        logic [CNT_W-1:0] t;
        if (ch == CH_SUS) begin
            case (code)
                2'b01:   t = CNT_W'(SUS_D1);
                2'b10:   t = CNT_W'(SUS_D2);
                2'b11:   t = CNT_W'(SUS_D3);
                default: t = '0;
            endcase
        end else begin
            case (code)
                2'b01:   t = CNT_W'(AUX_D1);
                2'b10:   t = CNT_W'(AUX_D2);
                2'b11:   t = CNT_W'(AUX_D3);
                default: t = '0;
            endcase
        end
        return t;
    endfunction

    function automatic logic skip_stretch(chan_e ch, logic dis, wake_ctx_e ctx);
        if (!dis) return 1'b0;
        if (ch == CH_SUS) return (ctx == CTX_COLD);
        return (ctx == CTX_COLD) || (ctx == CTX_DEEP);
    endfunction

endpackage

// File: rtl/sstr_cfg_regs.sv
module sstr_cfg_regs
    import sleep_stretch_pkg::*;
(
    input  logic       clk,
    input  logic       rtc_rst,
    input  logic       we,
    input  logic       lock,
    input  logic [1:0] aux_wdata,
    input  logic [1:0] sus_wdata,
    output logic [1:0] aux_code,
    output logic [1:0] sus_code
);

    always_ff @(posedge clk) begin
        if (rtc_rst) begin
            aux_code <= 2'b00;
            sus_code <= 2'b00;
        end else if (we && !lock) begin
            aux_code <= aux_wdata;
            sus_code <= sus_wdata;
        end
    end

endmodule

// File: rtl/sstr_channel.sv
module sstr_channel
    import sleep_stretch_pkg::*;
#(
    parameter chan_e KIND = CH_AUX
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       req,
    input  logic [1:0] code,
    input  logic       dis,
    input  wake_ctx_e  ctx,
    output logic       slp_n,
    output logic       stretching
);

    chan_state_t st;
    logic        reached;

    assign reached = (st.cnt >= st.lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (!st.active) begin
            if (req) begin
                st.active <= 1'b1;
                st.cnt    <= '0;
                st.lim    <= skip_stretch(KIND, dis, ctx) ? '0 : code_ticks(KIND, code);
            end
        end else begin
            if (tick && !reached) st.cnt <= st.cnt + CNT_W'(1);
            if (!req && reached)  st.active <= 1'b0;
        end
    end

    assign slp_n      = !st.active;
    assign stretching = st.active && !req;

endmodule

// File: rtl/sleep_stretcher.sv
module sleep_stretcher
    import sleep_stretch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rtc_rst,
    input  logic       tick_ms,
    input  logic       req_aux,
    input  logic       req_sus,
    input  logic       cfg_we,
    input  logic       cfg_lock,
    input  logic [1:0] cfg_aux_wdata,
    input  logic [1:0] cfg_sus_wdata,
    input  logic       cfg_dis_pwrup,
    input  logic [1:0] wake_ctx,
    output logic [1:0] aux_code,
    output logic [1:0] sus_code,
    output logic       slp_aux_n,
    output logic       slp_sus_n,
    output logic       aux_stretching,
    output logic       sus_stretching
);

    logic [1:0] code_v [NUM_CH];
    logic       req_v  [NUM_CH];
    logic       slp_v  [NUM_CH];
    logic       str_v  [NUM_CH];

    sstr_cfg_regs u_cfg (
        .clk       (clk),
        .rtc_rst   (rtc_rst),
        .we        (cfg_we),
        .lock      (cfg_lock),
        .aux_wdata (cfg_aux_wdata),
        .sus_wdata (cfg_sus_wdata),
        .aux_code  (aux_code),
        .sus_code  (sus_code)
    );

    assign code_v[CH_AUX] = aux_code;
    assign code_v[CH_SUS] = sus_code;
    assign req_v[CH_AUX]  = req_aux;
    assign req_v[CH_SUS]  = req_sus;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        sstr_channel #(.KIND(chan_e'(g))) u_ch (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick_ms),
            .req        (req_v[g]),
            .code       (code_v[g]),
            .dis        (cfg_dis_pwrup),
            .ctx        (wake_ctx_e'(wake_ctx)),
            .slp_n      (slp_v[g]),
            .stretching (str_v[g])
        );
    end

    assign slp_aux_n      = slp_v[CH_AUX];
    assign slp_sus_n      = slp_v[CH_SUS];
    assign aux_stretching = str_v[CH_AUX];
    assign sus_stretching = str_v[CH_SUS];

endmodule

// File: rtl/sleep_stretcher_chk.sv
module sleep_stretcher_chk (
    input logic       clk,
    input logic       rst,
    input logic       rtc_rst,
    input logic       cfg_we,
    input logic       cfg_lock,
    input logic       req_aux,
    input logic       req_sus,
    input logic [1:0] aux_code,
    input logic [1:0] sus_code,
    input logic       slp_aux_n,
    input logic       slp_sus_n,
    input logic       aux_stretching,
    input logic       sus_stretching
);

    AST_AUX_ASSERT_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        req_aux && slp_aux_n |=> !slp_aux_n); // R3
    AST_SUS_ASSERT_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        req_sus && slp_sus_n |=> !slp_sus_n); // R3
    AST_AUX_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
        req_aux && !slp_aux_n |=> !slp_aux_n); // R3
    AST_SUS_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
        req_sus && !slp_sus_n |=> !slp_sus_n); // R3
    AST_AUX_RELEASE_AFTER_DROP: assert property (@(posedge clk) disable iff (rst)
        $rose(slp_aux_n) |-> !$past(req_aux)); // R6
    AST_SUS_RELEASE_AFTER_DROP: assert property (@(posedge clk) disable iff (rst)
        $rose(slp_sus_n) |-> !$past(req_sus)); // R6
    AST_AUX_FLAG_MEANING: assert property (@(posedge clk) disable iff (rst)
        aux_stretching |-> !slp_aux_n && !req_aux); // R11
    AST_SUS_FLAG_MEANING: assert property (@(posedge clk) disable iff (rst)
        sus_stretching |-> !slp_sus_n && !req_sus); // R11
    AST_LOCK_FREEZES_CODES: assert property (@(posedge clk) disable iff (rst)
        cfg_lock && cfg_we && !rtc_rst |=> $stable(aux_code) && $stable(sus_code)); // R8
    AST_RTC_CLEARS_CODES: assert property (@(posedge clk) disable iff (rst)
        rtc_rst |=> aux_code == 2'b00 && sus_code == 2'b00); // R2

endmodule

bind sleep_stretcher sleep_stretcher_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .rtc_rst        (rtc_rst),
    .cfg_we         (cfg_we),
    .cfg_lock       (cfg_lock),
    .req_aux        (req_aux),
    .req_sus        (req_sus),
    .aux_code       (aux_code),
    .sus_code       (sus_code),
    .slp_aux_n      (slp_aux_n),
    .slp_sus_n      (slp_sus_n),
    .aux_stretching (aux_stretching),
    .sus_stretching (sus_stretching)
);

// File: tb/sleep_stretcher_tb.sv
module sleep_stretcher_tb;

    logic       clk = 1'b0;
    logic       rst, rtc_rst, tick_ms, req_aux, req_sus;
    logic       cfg_we, cfg_lock, cfg_dis_pwrup;
    logic [1:0] cfg_aux_wdata, cfg_sus_wdata, wake_ctx;
    logic [1:0] aux_code, sus_code;
    logic       slp_aux_n, slp_sus_n, aux_stretching, sus_stretching;

    int n_tests = 0;
    int n_fail  = 0;
    int low_c, str_c;

    always #4 clk = ~clk;

    sleep_stretcher u_dut (
        .clk(clk), .rst(rst), .rtc_rst(rtc_rst), .tick_ms(tick_ms),
        .req_aux(req_aux), .req_sus(req_sus), .cfg_we(cfg_we), .cfg_lock(cfg_lock),
        .cfg_aux_wdata(cfg_aux_wdata), .cfg_sus_wdata(cfg_sus_wdata),
        .cfg_dis_pwrup(cfg_dis_pwrup), .wake_ctx(wake_ctx),
        .aux_code(aux_code), .sus_code(sus_code),
        .slp_aux_n(slp_aux_n), .slp_sus_n(slp_sus_n),
        .aux_stretching(aux_stretching), .sus_stretching(sus_stretching)
    );

    typedef struct packed {
        logic        sus;
        logic [1:0]  code;
        logic [1:0]  ctx;
        logic        dis;
        logic [15:0] hold;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'b00, 2'b00, 1'b0, 16'd3},
        '{1'b0, 2'b10, 2'b00, 1'b0, 16'd5},
        '{1'b0, 2'b11, 2'b00, 1'b0, 16'd10},
        '{1'b0, 2'b01, 2'b00, 1'b0, 16'd1},
        '{1'b0, 2'b01, 2'b00, 1'b0, 16'd4500},
        '{1'b1, 2'b01, 2'b00, 1'b0, 16'd2},
        '{1'b1, 2'b10, 2'b00, 1'b0, 16'd1},
        '{1'b1, 2'b11, 2'b00, 1'b0, 16'd1},
        '{1'b1, 2'b00, 2'b00, 1'b0, 16'd7},
        '{1'b0, 2'b11, 2'b01, 1'b1, 16'd2},
        '{1'b0, 2'b11, 2'b10, 1'b1, 16'd2},
        '{1'b1, 2'b11, 2'b01, 1'b1, 16'd3},
        '{1'b1, 2'b10, 2'b10, 1'b1, 16'd2},
        '{1'b1, 2'b10, 2'b00, 1'b1, 16'd1},
        '{1'b0, 2'b10, 2'b01, 1'b0, 16'd1},
        '{1'b0, 2'b10, 2'b11, 1'b1, 16'd1}
    };

    function automatic int dur_ms(bit sus, logic [1:0] code);
        int aux_t [4] = '{0, 4000, 98, 2000};
        int sus_t [4] = '{0, 500, 1000, 4000};
        return sus ? sus_t[code] : aux_t[code];
    endfunction

    function automatic bit skipped(bit sus, bit dis, logic [1:0] ctx);
        if (!dis) return 1'b0;
        if (sus) return ctx == 2'b01;
        return ctx == 2'b01 || ctx == 2'b10;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_req(input bit sus, input bit v);
        if (sus) req_sus = v; else req_aux = v;
    endtask

    task automatic write_codes(input logic [1:0] a, input logic [1:0] s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_aux_wdata = a; cfg_sus_wdata = s;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Raises a request for 'hold' cycles and measures the low length and the flag-high cycles.
    // At cycle mid_at (if >0) a new auxiliary code mid_code is written.
    task automatic pulse(input bit sus, input int hold, input int mid_at, input logic [1:0] mid_code);
        @(negedge clk);
        set_req(sus, 1'b1);
        low_c = 0; str_c = 0;
        for (int i = 1; i < 6000; i++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            if (sus ? slp_sus_n : slp_aux_n) break;
            low_c++;
            if (sus ? sus_stretching : aux_stretching) str_c++;
            if (i >= hold) set_req(sus, 1'b0);
            if (i == mid_at) begin
                cfg_we = 1'b1; cfg_aux_wdata = mid_code; cfg_sus_wdata = sus_code;
            end
        end
        set_req(sus, 1'b0);
        cfg_we = 1'b0;
    endtask

    initial begin
        #1500000;
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; rtc_rst = 1'b1; tick_ms = 1'b1; req_aux = 1'b0; req_sus = 1'b0;
        cfg_we = 1'b0; cfg_lock = 1'b0; cfg_dis_pwrup = 1'b0; wake_ctx = 2'b00;
        cfg_aux_wdata = 2'b00; cfg_sus_wdata = 2'b00;
        repeat (3) @(negedge clk);
        // R1 / R2 reset state
        check(slp_aux_n && slp_sus_n, "R1 outputs high in reset", {slp_aux_n, slp_sus_n}, 3);
        check(!aux_stretching && !sus_stretching, "R1 flags low in reset",
              {aux_stretching, sus_stretching}, 0);
        check(aux_code == 0 && sus_code == 0, "R2 codes cleared", {aux_code, sus_code}, 0);
        rst = 1'b0; rtc_rst = 1'b0;

        // Table walk: R3 R4 R5 R6 R9 R10 R11
        for (int k = 0; k < NV; k++) begin
            int n, exp_len, exp_str;
            vec_t v = VECS[k];
            cfg_dis_pwrup = v.dis; wake_ctx = v.ctx;
            write_codes(v.sus ? 2'b00 : v.code, v.sus ? v.code : 2'b00);
            n = skipped(v.sus, v.dis, v.ctx) ? 0 : dur_ms(v.sus, v.code);
            exp_len = (int'(v.hold) > n + 1) ? int'(v.hold) : n + 1;
            exp_str = exp_len - int'(v.hold);
            pulse(v.sus, int'(v.hold), 0, 2'b00);
            check(low_c == exp_len, v.sus ? "R3/R4/R6/R10 suspend low length"
                                          : "R3/R5/R6/R9 aux low length", low_c, exp_len);
            check(str_c == exp_str, "R11 flag-high cycles", str_c, exp_str);
        end
        cfg_dis_pwrup = 1'b0; wake_ctx = 2'b00;

        // R7: code change mid-stretch
        write_codes(2'b10, 2'b00);
        pulse(1'b0, 1, 20, 2'b01);
        check(low_c == 99, "R7 old code kept during stretch", low_c, 99);
        check(aux_code == 2'b01, "R7 new code stored", aux_code, 1);
        pulse(1'b0, 1, 0, 2'b00);
        check(low_c == 4001, "R7 new code at next assertion", low_c, 4001);

        // R8: lock
        write_codes(2'b10, 2'b01);
        cfg_lock = 1'b1;
        write_codes(2'b11, 2'b11);
        check(aux_code == 2'b10 && sus_code == 2'b01, "R8 locked codes unchanged",
              {aux_code, sus_code}, 4'b1001);
        pulse(1'b1, 1, 0, 2'b00);
        check(low_c == 501, "R8 locked duration unchanged", low_c, 501);
        cfg_lock = 1'b0;

        // R6: no ticks, stretch does not expire
        tick_ms = 1'b0;
        @(negedge clk); req_aux = 1'b1;
        @(negedge clk); req_aux = 1'b0;
        repeat (300) @(negedge clk);
        check(!slp_aux_n && aux_stretching, "R6 held without ticks",
              {slp_aux_n, aux_stretching}, 1);
        tick_ms = 1'b1;
        repeat (100) @(negedge clk);
        check(slp_aux_n, "R6 release after ticks resume", slp_aux_n, 1);

        // R1: rst mid-stretch; R2: rst keeps codes
        @(negedge clk); req_sus = 1'b1;
        @(negedge clk); req_sus = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(slp_sus_n && !sus_stretching, "R1 rst releases output", slp_sus_n, 1);
        rst = 1'b0;
        check(aux_code == 2'b10 && sus_code == 2'b01, "R2 rst keeps codes",
              {aux_code, sus_code}, 4'b1001);
        rtc_rst = 1'b1;
        @(negedge clk);
        rtc_rst = 1'b0;
        check(aux_code == 0 && sus_code == 0, "R2 rtc_rst clears codes", {aux_code, sus_code}, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule